// File: doc/BRIEF.md
# Serial Flash Command Engine

This block turns register writes from a host into single-opcode SPI transactions to an external serial flash. The host sees three registers: a control word, an address and a data word. Setting the start bit of the control word launches one command. The engine first shifts out the opcode byte. Two phase bits in the control word then decide whether three address bytes follow and whether one data byte is exchanged. The command ends with chip select either released or still held.

The data phase is full duplex. The engine sends the low byte of the data register and, during the same eight clocks, captures the byte returned by the flash into that register. This one mechanism serves status reads, signature reads and single-byte programming. Holding chip select lets firmware chain plain one-byte commands into one long stream, such as a page program. The stream ends only when the host writes zero to the control word. The serial clock is SPI mode 0 and is derived from the system clock through a divider that the host can set.

Top module: `sfce_top`

## Requirements
- R1: After reset, chip select is high (`spi_cs_n`=1), `spi_sck` is low, and the control, address and data registers all read zero.
- R2: A write to the control register (offset 0x40) with bit 31 set, made while the engine is idle, pulls chip select low. It then shifts out control bits [7:0] MSB first in SPI mode 0: the clock idles low and the flash output is sampled on the rising edge.
- R3: Bit 31 of the control readback reads 1 from launch until the last byte is finished, and then clears. For a command of n bytes this takes no more than n*(16*(div+1)+4)+8 system clocks.
- R4: When control bit 9 is set, the opcode is followed by the three bytes of the address register (offset 0x44), most significant byte first.
- R5: When control bit 8 is set, one data byte follows the opcode and any address bytes. The engine sends bits [7:0] of the data register (offset 0x48), then loads that register with the received byte in bits [7:0] and zeros above.
- R6: When control bit 12 is set, chip select stays low after the command ends. The bytes of the next command continue the same transaction, with no new chip-select edge.
- R7: Writing the value zero to the control register while idle raises chip select and clears the control readback.
- R8: While busy, writes to the control, address and data registers have no effect.
- R9: Each high phase of `spi_sck` lasts `sck_div`+1 system clocks.
- R10: A start write in the cycle where the last byte completes is ignored. The first start write made after busy reads 0 is the one that launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| sck_div | input | 4 | Half-period of the serial clock minus one, in system clocks |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A host write to the control register and the completion of a command's last byte can fall in the same clock edge. The bench provokes this by writing a new start word on every cycle while a command runs, each with a different opcode. It notes the first cycle in which busy was seen low before the edge. The byte log of the flash model must then show that this cycle's opcode, and no earlier one, was the one that launched.

// File: rtl/sfce_pkg.sv
package sfce_pkg;
    localparam logic [7:0] OFF_CTRL = 8'h40;
    localparam logic [7:0] OFF_ADDR = 8'h44;
    localparam logic [7:0] OFF_DATA = 8'h48;

    localparam int START_BIT  = 31;
    localparam int HOLD_BIT   = 12;
    localparam int ADRPH_BIT  = 9;
    localparam int DATPH_BIT  = 8;
    localparam int CTRL_KEEP  = 13;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADR,
        PH_DAT
    } phase_e;
endpackage

// File: rtl/sfce_sck_div.sv
module sfce_sck_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == div_i);
        cnt_d  = (!en_i || tick_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/sfce_shift8.sv
module sfce_shift8 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] byte_i,
    input  logic         tick_i,
    input  logic         miso_i,
    output logic         active_o,
    output logic         sck_o,
    output logic         mosi_o,
    output logic         done_o,
    output logic [W-1:0] rx_o
);
    localparam int CNT_W = $clog2(W);

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [W-1:0]     tx;
        logic [W-1:0]     rx;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } sh_st_t;

    sh_st_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (load_i) begin
            sh_d.active = 1'b1;
            sh_d.sck    = 1'b0;
            sh_d.tx     = byte_i;
            sh_d.cnt    = '0;
        end else if (sh_q.active && tick_i) begin
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
                sh_d.rx  = {sh_q.rx[W-2:0], miso_i};
            end else begin
                sh_d.sck = 1'b0;
                sh_d.tx  = {sh_q.tx[W-2:0], 1'b0};
                sh_d.cnt = sh_q.cnt + 1'b1;
                if (sh_q.cnt == CNT_W'(W-1)) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign active_o = sh_q.active;
    assign sck_o    = sh_q.sck;
    assign mosi_o   = sh_q.tx[W-1];
    assign done_o   = sh_q.done;
    assign rx_o     = sh_q.rx;

    // R9
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(sck_o));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/sfce_top.sv
module sfce_top
    import sfce_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DIV_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [DIV_W-1:0] sck_div,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int ADDR_W = ADDR_BYTES * 8;
    localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    typedef struct packed {
        phase_e                ph;
        logic                  busy;
        logic                  cs_n;
        logic [CTRL_KEEP-1:0]  ctrl;
        logic [ADDR_W-1:0]     addr;
        logic [31:0]           data;
        logic [IDX_W-1:0]      idx;
        logic                  ld;
        logic [7:0]            byte_v;
    } eng_st_t;

    eng_st_t eng_d, eng_q;

    logic       sh_active, sh_done, sh_tick;
    logic [7:0] sh_rx;
    logic       go_adr, go_dat, go_end;
    logic [7:0] adr_byte;

    sfce_sck_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (sh_active),
        .div_i  (sck_div),
        .tick_o (sh_tick)
    );

    sfce_shift8 #(.W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (eng_q.ld),
        .byte_i   (eng_q.byte_v),
        .tick_i   (sh_tick),
        .miso_i   (spi_miso),
        .active_o (sh_active),
        .sck_o    (spi_sck),
        .mosi_o   (spi_mosi),
        .done_o   (sh_done),
        .rx_o     (sh_rx)
    );

    always_comb begin
        adr_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (IDX_W'(i) == eng_q.idx - 1'b1) adr_byte = eng_q.addr[8*i +: 8];
        end
    end

    always_comb begin
        eng_d    = eng_q;
        eng_d.ld = 1'b0;
        go_adr   = 1'b0;
        go_dat   = 1'b0;
        go_end   = 1'b0;

        if (reg_we && !eng_q.busy) begin
            case (reg_addr)
                OFF_CTRL: begin
                    if (reg_wdata[START_BIT]) begin
                        eng_d.ctrl   = reg_wdata[CTRL_KEEP-1:0];
                        eng_d.busy   = 1'b1;
                        eng_d.cs_n   = 1'b0;
                        eng_d.ph     = PH_OPC;
                        eng_d.ld     = 1'b1;
                        eng_d.byte_v = reg_wdata[7:0];
                    end else if (reg_wdata == '0) begin
                        eng_d.ctrl = '0;
                        eng_d.cs_n = 1'b1;
                    end
                end
                OFF_ADDR: eng_d.addr = reg_wdata[ADDR_W-1:0];
                OFF_DATA: eng_d.data = reg_wdata;
                default:  ;
            endcase
        end

        if (sh_done) begin
            case (eng_q.ph)
                PH_OPC: begin
                    if (eng_q.ctrl[ADRPH_BIT])      go_adr = 1'b1;
                    else if (eng_q.ctrl[DATPH_BIT]) go_dat = 1'b1;
                    else                            go_end = 1'b1;
                end
                PH_ADR: begin
                    if (eng_q.idx != '0) begin
                        eng_d.idx    = eng_q.idx - 1'b1;
                        eng_d.ld     = 1'b1;
                        eng_d.byte_v = adr_byte;
                    end else if (eng_q.ctrl[DATPH_BIT]) begin
                        go_dat = 1'b1;
                    end else begin
                        go_end = 1'b1;
                    end
                end
                PH_DAT: begin
                    eng_d.data = {24'h0, sh_rx};
                    go_end     = 1'b1;
                end
                default: go_end = 1'b1;
            endcase
        end

        if (go_adr) begin
            eng_d.ph     = PH_ADR;
            eng_d.idx    = IDX_W'(ADDR_BYTES - 1);
            eng_d.ld     = 1'b1;
            eng_d.byte_v = eng_q.addr[ADDR_W-1 -: 8];
        end
        if (go_dat) begin
            eng_d.ph     = PH_DAT;
            eng_d.ld     = 1'b1;
            eng_d.byte_v = eng_q.data[7:0];
        end
        if (go_end) begin
            eng_d.ph   = PH_IDLE;
            eng_d.busy = 1'b0;
            eng_d.cs_n = !eng_q.ctrl[HOLD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.ph   <= PH_IDLE;
            eng_q.cs_n <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = {eng_q.busy, {(31-CTRL_KEEP){1'b0}}, eng_q.ctrl};
            OFF_ADDR: reg_rdata = 32'(eng_q.addr);
            OFF_DATA: reg_rdata = eng_q.data;
            default:  reg_rdata = '0;
        endcase
    end

    assign spi_cs_n = eng_q.cs_n;

    // R3
    busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.busy |-> !spi_cs_n);
    // R8
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.busy && $past(eng_q.busy)) |-> $stable(eng_q.addr));
    // R7
    cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !eng_q.busy);
    // R2
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.ld |-> (eng_q.busy && !sh_active));
endmodule

// File: tb/sfce_top_bench.sv
module sfce_top_bench;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_ADDR = 8'h44;
    localparam logic [7:0] A_DATA = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h40;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  sck_div = 4'd0;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int errors = 0;

    sfce_top u_sfce_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_div(sck_div),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    // flash model: logs bytes on MOSI, returns resp on MISO MSB first
    logic [7:0] flog [0:63];
    int         nlog = 0;
    int         fbit = 0;
    logic [7:0] fsh = '0;
    logic [7:0] resp = 8'h00;
    int         cs_rises = 0;
    int         hi_cnt = 0, hi_min = 1000, hi_max = 0;

    assign spi_miso = resp[3'(7 - fbit)];

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            fsh = {fsh[6:0], spi_mosi};
            fbit = fbit + 1;
            if (fbit == 8) begin
                if (nlog < 64) flog[nlog] = fsh;
                nlog = nlog + 1;
                fbit = 0;
            end
        end
    end
    always @(posedge spi_cs_n) cs_rises = cs_rises + 1;
    always @(negedge clk) if (spi_sck) hi_cnt = hi_cnt + 1;
    always @(negedge spi_sck) begin
        if (hi_cnt < hi_min) hi_min = hi_cnt;
        if (hi_cnt > hi_max) hi_max = hi_cnt;
        hi_cnt = 0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_CTRL;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_CTRL;
    endtask

    task automatic wait_idle(input int nbytes, output int cyc);
        int bound;
        bound = nbytes * (16 * (int'(sck_div) + 1) + 4) + 8;
        cyc = 0;
        reg_addr = A_CTRL;
        #1;
        while (reg_rdata[31] && cyc <= bound) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        chk(cyc <= bound, "R3 busy bound", cyc, bound);
    endtask

    task automatic cmd(input logic [31:0] c, input int nbytes);
        int cyc;
        nlog = 0;
        hi_min = 1000; hi_max = 0;
        wr(A_CTRL, c);
        wait_idle(nbytes, cyc);
    endtask

    initial begin
        int wd = 0;
        while (wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        errors++; checks++;
        $display("FAIL R3 watchdog actual=%0d expected=finish", wd);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  prev;
        logic [23:0] adrs [0:3];
        int          rises0;
        logic [7:0]  k, exp_k;
        bit          launched;
        int          guard;
        int          cyc;

        adrs[0] = 24'h123456; adrs[1] = 24'hFFFFFF;
        adrs[2] = 24'h000001; adrs[3] = 24'hA5C33C;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n === 1'b1, "R1 cs_n", 32'(spi_cs_n), 1);
        chk(spi_sck === 1'b0, "R1 sck", 32'(spi_sck), 0);
        rd(A_CTRL, v); chk(v === 0, "R1 ctrl", v, 0);
        rd(A_ADDR, v); chk(v === 0, "R1 addr", v, 0);
        rd(A_DATA, v); chk(v === 0, "R1 data", v, 0);

        // R2 sweep of every opcode, opcode-only command
        for (int op = 0; op < 256; op++) begin
            cmd(32'h8000_0000 | 32'(op), 1);
            chk(nlog == 1 && flog[0] == 8'(op), "R2 opcode byte", 32'(flog[0]), 32'(op));
            chk(spi_cs_n === 1'b1, "R2 cs released", 32'(spi_cs_n), 1);
        end

        // R9 divider sweep
        for (int d = 0; d < 4; d++) begin
            sck_div = 4'(d);
            cmd(32'h8000_00C7, 1);
            chk(hi_min == d + 1 && hi_max == d + 1, "R9 sck high phase",
                32'(hi_max), 32'(d + 1));
        end
        sck_div = 4'd0;

        // R4 address-only command
        for (int i = 0; i < 4; i++) begin
            wr(A_ADDR, 32'(adrs[i]));
            cmd(32'h8000_02D8, 4);
            chk(nlog == 4 && flog[0] == 8'hD8 && flog[1] == adrs[i][23:16] &&
                flog[2] == adrs[i][15:8] && flog[3] == adrs[i][7:0],
                "R4 address bytes",
                {flog[0], flog[1], flog[2], flog[3]},
                {8'hD8, adrs[i]});
        end

        // R5 status-style data exchange over all response values
        wr(A_DATA, 32'hDEADBE5A);
        prev = 8'h5A;
        for (int r = 0; r < 256; r++) begin
            resp = 8'(r);
            cmd(32'h8000_0105, 2);
            chk(nlog == 2 && flog[0] == 8'h05 && flog[1] == prev, "R5 data byte sent",
                32'(flog[1]), 32'(prev));
            rd(A_DATA, v);
            chk(v == 32'(r), "R5 received byte", v, 32'(r));
            prev = 8'(r);
        end

        // R4 R5 signature read: address then data
        resp = 8'hBF;
        wr(A_ADDR, 32'h0000_0001);
        cmd(32'h8000_03AB, 5);
        chk(nlog == 5 && flog[0] == 8'hAB && flog[1] == 8'h00 && flog[2] == 8'h00 &&
            flog[3] == 8'h01, "R4 signature address", 32'(flog[3]), 32'h01);
        rd(A_DATA, v); chk(v == 32'hBF, "R5 signature capture", v, 32'hBF);

        // R6 held chip select across chained commands
        resp = 8'h00;
        wr(A_ADDR, 32'h00_0100);
        wr(A_DATA, 32'h11);
        rises0 = cs_rises;
        cmd(32'h8000_1302, 5);
        chk(spi_cs_n === 1'b0, "R6 cs held", 32'(spi_cs_n), 0);
        wr(A_CTRL, 32'h8000_10AA); wait_idle(1, cyc);
        wr(A_CTRL, 32'h8000_10BB); wait_idle(1, cyc);
        chk(nlog == 7 && flog[4] == 8'h11 && flog[5] == 8'hAA && flog[6] == 8'hBB,
            "R6 continued stream", {8'(nlog), flog[4], flog[5], flog[6]}, 32'h0711AABB);
        chk(cs_rises == rises0 && spi_cs_n === 1'b0, "R6 no cs edge",
            32'(cs_rises), 32'(rises0));
        // R7 zero write ends the held transaction
        wr(A_CTRL, 32'h0);
        chk(spi_cs_n === 1'b1 && cs_rises == rises0 + 1, "R7 cs released",
            32'(spi_cs_n), 1);
        rd(A_CTRL, v); chk(v == 0, "R7 ctrl cleared", v, 0);

        // R8 writes while busy are ignored
        resp = 8'h3C;
        wr(A_ADDR, 32'h00ABCDEF);
        nlog = 0;
        wr(A_CTRL, 32'h8000_03AB);
        wr(A_CTRL, 32'h8000_0011);
        wr(A_ADDR, 32'h0099_9999);
        wr(A_DATA, 32'h0000_1234);
        wr(A_CTRL, 32'h0);
        wait_idle(5, cyc);
        chk(nlog == 5 && flog[0] == 8'hAB && flog[1] == 8'hAB && flog[3] == 8'hEF,
            "R8 command unchanged", {8'(nlog), flog[0], flog[1], flog[3]}, 32'h05ABABEF);
        rd(A_ADDR, v); chk(v == 32'h00ABCDEF, "R8 addr kept", v, 32'h00ABCDEF);
        rd(A_CTRL, v); chk(v == 32'h0000_03AB, "R8 ctrl kept", v, 32'h0000_03AB);
        rd(A_DATA, v); chk(v == 32'h3C, "R8 data kept", v, 32'h3C);
        chk(spi_cs_n === 1'b1, "R8 cs released", 32'(spi_cs_n), 1);

        // R10 start write racing the completion edge
        nlog = 0;
        wr(A_CTRL, 32'h8000_00C7);
        k = 8'h10; exp_k = 8'h00; launched = 1'b0; guard = 0;
        while (!launched && guard < 1000) begin
            @(negedge clk);
            reg_addr = A_CTRL;
            #1;
            if (!reg_rdata[31]) begin
                exp_k = k;
                launched = 1'b1;
            end
            reg_we = 1'b1; reg_wdata = 32'h8000_0000 | 32'(k);
            k = k + 8'd1;
            guard++;
        end
        @(negedge clk);
        reg_we = 1'b0;
        wait_idle(1, cyc);
        chk(nlog == 2 && flog[0] == 8'hC7 && flog[1] == exp_k, "R10 launch boundary",
            32'(flog[1]), 32'(exp_k));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule